// File: doc/BRIEF.md
# Conditional Flag Branch Unit

This block keeps a 16-bit flag register and resolves the control flow of one flag-conditional instruction per issue. Each instruction carries one of eight operation classes: halt-jump, execute-at-address, link, link-with-clear, jump, jump-with-clear, jump-with-set and jump-with-toggle. It also carries a 5-bit condition code, the effective address E and the current location counter L. The condition code names one flag bit. It either tests that bit for one, or it tests the inverted bit.

One cycle after an issue, the unit presents the next location counter. It also presents a link write to memory, a halt request, a privilege-trap request or an execute request, as the operation calls for. The jump-with-clear, jump-with-set, jump-with-toggle and link-with-clear classes modify the selected flag whether or not the condition holds. The condition is always judged on the value the flag had before that change.

The whole flag register is visible on an output and can be overwritten by a load strobe. Flag bit 0 is permanently one. In user mode, the interrupt-enable flag (bit 7) is protected from any change.

Top module: `cfb_branch_unit`

## Requirements
- R1: After synchronous reset the flag output reads 16'h0001 and done, link_we, exec_req, halt_req and trap_req are all 0.
- R2: Condition code bits 3:0 select flag bit n. Bit 4 set means the inverse test. The condition is true when flag[n] XOR cond[4] is 1. Operation encodings are: 0 halt-jump, 1 execute, 2 link, 3 link-clear, 4 jump, 5 jump-clear, 6 jump-set, 7 jump-toggle.
- R3: Flag bit 0 always reads 1 and no operation or load can clear it. Code 0 is therefore always true and code 16 is always false.
- R4: Jump-clear and link-clear clear the selected flag, jump-set sets it, and jump-toggle complements it. This happens whether or not the condition is true, and the condition uses the flag value from before the change.
- R5: A true link or link-clear raises link_we with link_addr = E and link_data = L+1, and sets next_loc = E+1. All address arithmetic wraps modulo 2^ADDR_W.
- R6: A true jump of any of the four jump classes sets next_loc = E. A false condition on any class sets next_loc = L+1 and raises no halt, trap, execute or link strobe.
- R7: A true halt-jump in monitor mode (user_mode = 0) raises halt_req with next_loc = E. In user mode it instead raises trap_req (internal interrupt 2) with next_loc = L+1.
- R8: A true execute raises exec_req for one cycle with exec_addr = E and next_loc = L+1.
- R9: All results and the flag update appear one clock after issue. done is high for exactly that one cycle, and every strobe is low whenever done is low.
- R10: While user_mode is 1, flag bit 7 is changed neither by an operation side effect nor by a flag load.
- R11: A flag load writes flag_wdata into bits 15:1 in the next cycle. If a load and an issue fall in the same cycle, the load decides the new flag value and the issue still produces its control results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction valid this cycle |
| op | input | 3 | Operation class |
| cond | input | 5 | Condition code: {invert, flag index} |
| ea | input | ADDR_W | Effective address E |
| loc | input | ADDR_W | Current location counter L |
| user_mode | input | 1 | 1 = user mode, 0 = monitor mode |
| flag_ld | input | 1 | Load the flag register |
| flag_wdata | input | 16 | Flag load value |
| flags | output | 16 | Current flag register |
| done | output | 1 | Results valid (one cycle after issue) |
| next_loc | output | ADDR_W | Next location counter |
| link_we | output | 1 | Link write strobe |
| link_addr | output | ADDR_W | Link write address |
| link_data | output | ADDR_W | Link write data (return address) |
| exec_req | output | 1 | Execute-at-address request |
| exec_addr | output | ADDR_W | Address of instruction to execute |
| halt_req | output | 1 | Machine halt request |
| trap_req | output | 1 | Privilege trap (internal interrupt 2) |

## Verification
Every result of an issue is due on the first rising edge after the issue is sampled: next_loc, the strobes, the link and execute addresses, and the modified flag. A flag load is likewise visible one edge later. The bench drives inputs on falling edges and reads outputs on the following falling edge, half a cycle after the edge that registered them. It also reads done and the flags on the falling edge after that, to confirm the one-cycle pulse. The sweep covers every operation class with every condition code in both modes, reloading a known flag pattern before each case.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int FLAG_W     = 16;
    localparam int FIDX_W     = $clog2(FLAG_W);
    localparam int COND_W     = FIDX_W + 1;
    localparam int ENABLE_BIT = 7;
    localparam logic [FLAG_W-1:0] FLAG_RST = {{(FLAG_W-1){1'b0}}, 1'b1};

    typedef enum logic [2:0] {
        OP_HALTJ = 3'd0,
        OP_EXEC  = 3'd1,
        OP_LINK  = 3'd2,
        OP_LINKC = 3'd3,
        OP_JUMP  = 3'd4,
        OP_JUMPC = 3'd5,
        OP_JUMPS = 3'd6,
        OP_JUMPT = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        FX_NONE,
        FX_CLR,
        FX_SET,
        FX_TGL
    } fx_e;

    typedef struct packed {
        logic [FIDX_W-1:0] idx;
        logic              inv;
    } cond_t;

    function automatic cond_t split_cond(input logic [COND_W-1:0] c);
        cond_t r;
        r.idx = c[FIDX_W-1:0];
        r.inv = c[COND_W-1];
        return r;
    endfunction

    function automatic fx_e op_fx(input op_e o);
        unique case (o)
            OP_LINKC, OP_JUMPC: return FX_CLR;
            OP_JUMPS:           return FX_SET;
            OP_JUMPT:           return FX_TGL;
            default:            return FX_NONE;
        endcase
    endfunction
endpackage

// File: rtl/cfb_cond_eval.sv
module cfb_cond_eval
    import cfb_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  cond_t             cnd,
    output logic              hit
);
    always_comb begin
        hit = flags[cnd.idx] ^ cnd.inv;
    end
endmodule

// File: rtl/cfb_flag_update.sv
module cfb_flag_update
    import cfb_pkg::*;
(
    input  logic [FLAG_W-1:0] flags_q,
    input  logic              issue,
    input  fx_e               fx,
    input  logic [FIDX_W-1:0] idx,
    input  logic              user_mode,
    input  logic              ld,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags_d
);
    assign flags_d[0] = 1'b1;

    for (genvar i = 1; i < FLAG_W; i++) begin : g_bit
        logic locked;
        logic sel;
        if (i == ENABLE_BIT) begin : g_en
            assign locked = user_mode;
        end else begin : g_gp
            assign locked = 1'b0;
        end
        assign sel = issue && (idx == FIDX_W'(i));

        always_comb begin
            flags_d[i] = flags_q[i];
            if (!locked) begin
                if (ld) begin
                    flags_d[i] = wdata[i];
                end else if (sel) begin
                    unique case (fx)
                        FX_CLR:  flags_d[i] = 1'b0;
                        FX_SET:  flags_d[i] = 1'b1;
                        FX_TGL:  flags_d[i] = ~flags_q[i];
                        default: flags_d[i] = flags_q[i];
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/cfb_ctrl.sv
module cfb_ctrl
    import cfb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  op_e               op,
    input  logic              hit,
    input  logic              user_mode,
    input  logic [ADDR_W-1:0] ea,
    input  logic [ADDR_W-1:0] loc,
    output logic [ADDR_W-1:0] next_loc,
    output logic              link_we,
    output logic              exec_req,
    output logic              halt_req,
    output logic              trap_req
);
    logic [ADDR_W-1:0] loc_inc;
    logic [ADDR_W-1:0] ea_inc;

    assign loc_inc = loc + 1'b1;
    assign ea_inc  = ea + 1'b1;

    always_comb begin
        next_loc = loc_inc;
        link_we  = 1'b0;
        exec_req = 1'b0;
        halt_req = 1'b0;
        trap_req = 1'b0;
        if (hit) begin
            unique case (op)
                OP_HALTJ: begin
                    if (user_mode) begin
                        trap_req = 1'b1;
                    end else begin
                        halt_req = 1'b1;
                        next_loc = ea;
                    end
                end
                OP_EXEC: exec_req = 1'b1;
                OP_LINK, OP_LINKC: begin
                    link_we  = 1'b1;
                    next_loc = ea_inc;
                end
                default: next_loc = ea;
            endcase
        end
    end
endmodule

// File: rtl/cfb_branch_unit.sv
module cfb_branch_unit
    import cfb_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue,
    input  logic [2:0]           op,
    input  logic [COND_W-1:0]    cond,
    input  logic [ADDR_W-1:0]    ea,
    input  logic [ADDR_W-1:0]    loc,
    input  logic                 user_mode,
    input  logic                 flag_ld,
    input  logic [FLAG_W-1:0]    flag_wdata,
    output logic [FLAG_W-1:0]    flags,
    output logic                 done,
    output logic [ADDR_W-1:0]    next_loc,
    output logic                 link_we,
    output logic [ADDR_W-1:0]    link_addr,
    output logic [ADDR_W-1:0]    link_data,
    output logic                 exec_req,
    output logic [ADDR_W-1:0]    exec_addr,
    output logic                 halt_req,
    output logic                 trap_req
);
    op_e               op_i;
    cond_t             cnd;
    logic              hit;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;
    logic [ADDR_W-1:0] nl_c;
    logic              lw_c, ex_c, ht_c, tr_c;

    assign op_i = op_e'(op);
    assign cnd  = split_cond(cond);

    cfb_cond_eval u_eval (
        .flags (flags_q),
        .cnd   (cnd),
        .hit   (hit)
    );

    cfb_flag_update u_upd (
        .flags_q   (flags_q),
        .issue     (issue),
        .fx        (op_fx(op_i)),
        .idx       (cnd.idx),
        .user_mode (user_mode),
        .ld        (flag_ld),
        .wdata     (flag_wdata),
        .flags_d   (flags_d)
    );

    cfb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .op        (op_i),
        .hit       (hit),
        .user_mode (user_mode),
        .ea        (ea),
        .loc       (loc),
        .next_loc  (nl_c),
        .link_we   (lw_c),
        .exec_req  (ex_c),
        .halt_req  (ht_c),
        .trap_req  (tr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q   <= FLAG_RST;
            done      <= 1'b0;
            link_we   <= 1'b0;
            exec_req  <= 1'b0;
            halt_req  <= 1'b0;
            trap_req  <= 1'b0;
            next_loc  <= '0;
            link_addr <= '0;
            link_data <= '0;
            exec_addr <= '0;
        end else begin
            flags_q  <= flags_d;
            done     <= issue;
            link_we  <= issue && lw_c;
            exec_req <= issue && ex_c;
            halt_req <= issue && ht_c;
            trap_req <= issue && tr_c;
            if (issue) begin
                next_loc  <= nl_c;
                link_addr <= ea;
                link_data <= loc + 1'b1;
                exec_addr <= ea;
            end
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              issue,
    input logic [ADDR_W-1:0] ea,
    input logic [ADDR_W-1:0] loc,
    input logic              user_mode,
    input logic [15:0]       flags,
    input logic              done,
    input logic [ADDR_W-1:0] next_loc,
    input logic              link_we,
    input logic [ADDR_W-1:0] link_addr,
    input logic [ADDR_W-1:0] link_data,
    input logic              exec_req,
    input logic              halt_req,
    input logic              trap_req
);
    AST_FLAG0_ONE: assert property (@(posedge clk) disable iff (rst)
        flags[0] == 1'b1); // R3

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({halt_req, trap_req, exec_req, link_we})); // R6

    AST_STROBE_DONE: assert property (@(posedge clk) disable iff (rst)
        (halt_req || trap_req || exec_req || link_we) |-> done); // R9

    AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(issue)); // R9

    AST_LINK_RETURN: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == $past(loc) + 1'b1 &&
                     next_loc == link_addr + 1'b1)); // R5

    AST_HALT_MONITOR: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (!$past(user_mode) && next_loc == $past(ea))); // R7

    AST_TRAP_USER: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(user_mode)); // R7

    AST_ENABLE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        $past(user_mode) |-> flags[7] == $past(flags[7])); // R10
endmodule

bind cfb_branch_unit cfb_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_cfb_branch_unit.sv
`timescale 1ns/1ps
module tb_cfb_branch_unit;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          issue;
    logic [2:0]    op;
    logic [4:0]    cond;
    logic [AW-1:0] ea, loc;
    logic          user_mode;
    logic          flag_ld;
    logic [15:0]   flag_wdata;
    logic [15:0]   flags;
    logic          done;
    logic [AW-1:0] next_loc;
    logic          link_we;
    logic [AW-1:0] link_addr, link_data;
    logic          exec_req;
    logic [AW-1:0] exec_addr;
    logic          halt_req, trap_req;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    cfb_branch_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .issue(issue), .op(op), .cond(cond),
        .ea(ea), .loc(loc), .user_mode(user_mode), .flag_ld(flag_ld),
        .flag_wdata(flag_wdata), .flags(flags), .done(done),
        .next_loc(next_loc), .link_we(link_we), .link_addr(link_addr),
        .link_data(link_data), .exec_req(exec_req), .exec_addr(exec_addr),
        .halt_req(halt_req), .trap_req(trap_req)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat, f0, fe;
        logic [3:0]  fi;
        logic        hit;
        logic [AW-1:0] e_next;
        logic [3:0]  e_strb;
        string       tag;
        int          ncase;

        rst = 1; issue = 0; op = 0; cond = 0; ea = 0; loc = 0;
        user_mode = 0; flag_ld = 0; flag_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(flags == 16'h0001, "R1 flags", flags, 16'h0001);
        chk({done, link_we, exec_req, halt_req, trap_req} == 5'b0, "R1 strobes",
            {done, link_we, exec_req, halt_req, trap_req}, 0);

        ncase = 0;
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 8; o++) begin
                for (int c = 0; c < 32; c++) begin
                    ncase++;
                    pat = ncase[0] ? 16'h5A3C : 16'hA5C3;
                    flag_ld = 1; flag_wdata = pat; user_mode = 0; issue = 0;
                    @(negedge clk);
                    f0 = pat | 16'h0001;
                    chk(done == 1'b0, "R9 done pulse", done, 0);
                    chk(flags == f0, "R11 load", flags, f0);
                    flag_ld = 0; issue = 1; op = 3'(o); cond = 5'(c);
                    user_mode = m[0];
                    ea  = 16'h1234 ^ AW'(o << 8) ^ AW'(c);
                    loc = 16'hFFE0 + AW'(c);
                    @(negedge clk);
                    issue = 0;
                    fi  = 4'(c);
                    hit = f0[fi] ^ c[4];
                    e_next = loc + 16'd1;
                    e_strb = 4'b0000; // {halt, trap, exec, link}
                    tag = "R6";
                    if (hit) begin
                        case (o)
                            0: begin
                                tag = "R7";
                                if (m == 1) e_strb = 4'b0100;
                                else begin e_strb = 4'b1000; e_next = ea; end
                            end
                            1: begin tag = "R8"; e_strb = 4'b0010; end
                            2, 3: begin tag = "R5"; e_strb = 4'b0001; e_next = ea + 16'd1; end
                            default: e_next = ea;
                        endcase
                    end
                    fe = f0;
                    if (!(fi == 0 || (fi == 7 && m == 1))) begin
                        case (o)
                            3, 5: fe[fi] = 1'b0;
                            6:    fe[fi] = 1'b1;
                            7:    fe[fi] = ~f0[fi];
                            default: ;
                        endcase
                    end
                    chk(done == 1'b1, "R9 done", done, 1);
                    chk(next_loc == e_next, tag, next_loc, e_next);
                    chk({halt_req, trap_req, exec_req, link_we} == e_strb, "R2 strobes",
                        {halt_req, trap_req, exec_req, link_we}, e_strb);
                    if (e_strb[0]) begin
                        chk(link_addr == ea, "R5 addr", link_addr, ea);
                        chk(link_data == AW'(loc + 16'd1), "R5 data", link_data, loc + 16'd1);
                    end
                    if (e_strb[1]) chk(exec_addr == ea, "R8 addr", exec_addr, ea);
                    if (fi == 0)
                        chk(flags == fe, "R3 flags", flags, fe);
                    else if (fi == 7 && m == 1)
                        chk(flags == fe, "R10 flags", flags, fe);
                    else
                        chk(flags == fe, "R4 flags", flags, fe);
                end
            end
        end

        // user-mode loads keep bit 7 and bit 0
        @(negedge clk);
        flag_ld = 1; flag_wdata = 16'hA5C3; user_mode = 0;
        @(negedge clk);
        flag_wdata = 16'h0000; user_mode = 1;
        @(negedge clk);
        chk(flags == 16'h0081, "R10 load keep set", flags, 16'h0081);
        flag_wdata = 16'h0000; user_mode = 0;
        @(negedge clk);
        flag_wdata = 16'hFFFF; user_mode = 1;
        @(negedge clk);
        chk(flags == 16'hFF7F, "R10 load keep clear", flags, 16'hFF7F);

        // load and issue together: load wins on flags, issue still resolves
        flag_wdata = 16'h0000; user_mode = 0; flag_ld = 1;
        issue = 1; op = 3'd6; cond = 5'd9; ea = 16'h0400; loc = 16'h0100;
        @(negedge clk);
        flag_ld = 0; issue = 0;
        chk(flags == 16'h0001, "R11 collision flags", flags, 16'h0001);
        chk(next_loc == 16'h0400, "R11 collision jump", next_loc, 16'h0400);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule